// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of the cache-line misses a non-blocking data cache has outstanding, so that an in-order pipeline can let a missing load leave while its data is still on the way. Each tracking entry names one memory line. For every word position in that line it records the destination register that waits on the word, if there is one. A load that misses either opens a new entry, which raises one memory request, or joins an entry already open for the same line, which raises no request. The block also keeps a full/empty bit for every architectural register. A load that is accepted marks its destination Empty, and the decode stage asks the block whether a source register is still Empty so it can hold the instruction.

When the memory side returns a whole line for an entry, the block writes each waiting word into its register, one per cycle in ascending word order, and sets that register Full. It releases the entry in the cycle after the last of these writebacks. Three ports are valid/ready streams. On the miss port, `miss_ready` may fall at any time and the pipeline keeps the load asserted until a cycle where both signals are high. On the memory request port, once `mreq_valid` is high it stays high with the same `mreq_idx` and `mreq_line` until `mreq_ready` is seen. On the fill port, a fill is taken only in a cycle where `fill_ready` is high. The writeback and decode query pins are plain and cannot be stalled.

Top module: `mshr_file`

## Requirements
- R1: After reset every register reads Full (`dec_hold` low for any `dec_rs`), `mreq_valid` and `wb_valid` are low, and `fill_ready` is high.
- R2: A miss to a line held by no entry is accepted into the lowest-numbered free entry. That entry then drives `mreq_valid` with its index and line, and the request is held unchanged until `mreq_ready` is high.
- R3: A miss to a line already held by a waiting entry is merged into that entry and produces no new memory request.
- R4: An accepted miss marks its destination register Empty, so `dec_hold` is high while `dec_rs` names that register.
- R5: When all entries are in use, a miss to a new line sees `miss_ready` low, while a merge into an existing line is still accepted.
- R6: A merge whose word position already holds a waiting register sees `miss_ready` low.
- R7: A miss whose destination register is still Empty sees `miss_ready` low.
- R8: A fill (line word k at `fill_data[k*DATA_W +: DATA_W]`) writes each waiting word, in ascending word order and one per cycle from the cycle after the fill is taken, as `wb_valid`/`wb_rd`/`wb_data`. Each written register becomes Full.
- R9: The entry is released in the cycle after its last writeback. Until then `fill_ready` is low, and a miss to that line sees `miss_ready` low.
- R10: Among entries whose request has not been sent, and with no request held, the lowest index is presented on `mreq_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | A load missed and waits for acceptance |
| miss_ready | output | 1 | The miss can be accepted this cycle |
| miss_line | input | LINE_W | Line address of the missing load |
| miss_word | input | clog2(WORDS) | Word position inside the line |
| miss_rd | input | clog2(NUM_REGS) | Destination register of the load |
| mreq_valid | output | 1 | A line fetch is requested |
| mreq_ready | input | 1 | Memory side takes the request |
| mreq_line | output | LINE_W | Line address to fetch |
| mreq_idx | output | clog2(NUM_ENTRIES) | Entry that the fill must name |
| fill_valid | input | 1 | A fetched line is presented |
| fill_ready | output | 1 | Fill can be taken this cycle |
| fill_idx | input | clog2(NUM_ENTRIES) | Entry the line belongs to |
| fill_data | input | WORDS*DATA_W | Whole line, word k in slice k |
| wb_valid | output | 1 | Register write this cycle |
| wb_rd | output | clog2(NUM_REGS) | Register written |
| wb_data | output | DATA_W | Value written |
| dec_rs | input | clog2(NUM_REGS) | Source register queried by decode |
| dec_hold | output | 1 | Queried register is Empty; hold decode |

## Verification
The bench fills every entry and then tries a fifth line. A design without the full check would overwrite a live entry and lose a pending register. It tries a merge into an occupied word slot and a load into a register that is already Empty. Both must be refused, or one waiting register would be silently dropped. It checks that a merge raises no second fetch, that the writebacks come out in ascending word order with the matching line words, and that the entry stays busy for exactly one idle cycle after the last write. A design that released early or late would take a miss to the draining line, or would refuse the next fill or allocation for too long.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    ENT_FREE  = 2'd0,
    ENT_WAIT  = 2'd1,
    ENT_DRAIN = 2'd2
  } ent_state_t;
endpackage

// File: rtl/mshr_lowest.sv
module mshr_lowest #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/mshr_entry.sv
module mshr_entry
  import mshr_pkg::*;
#(
  parameter int LINE_W = 28,
  parameter int WORDS  = 4,
  parameter int RD_W   = 5,
  localparam int WI_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_i,
  input  logic                  merge_i,
  input  logic [WI_W-1:0]       word_i,
  input  logic [RD_W-1:0]       rd_i,
  input  logic [LINE_W-1:0]     line_i,
  input  logic                  sent_i,
  input  logic                  drain_i,
  input  logic                  clr_i,
  input  logic [WI_W-1:0]       clr_word_i,
  input  logic                  release_i,
  output ent_state_t            state_o,
  output logic                  sent_o,
  output logic [LINE_W-1:0]     line_o,
  output logic [WORDS-1:0]      pend_o,
  output logic [WORDS*RD_W-1:0] rds_o
);
  ent_state_t            state_q;
  logic                  sent_q;
  logic [LINE_W-1:0]     line_q;
  logic [WORDS-1:0]      pend_q;
  logic [RD_W-1:0]       rds_q [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ENT_FREE;
      sent_q  <= 1'b0;
      pend_q  <= '0;
      line_q  <= '0;
    end else begin
      if (alloc_i) begin
        state_q <= ENT_WAIT;
        sent_q  <= 1'b0;
        line_q  <= line_i;
        pend_q  <= WORDS'(1) << word_i;
      end
      if (merge_i) pend_q[word_i] <= 1'b1;
      if (sent_i) sent_q <= 1'b1;
      if (drain_i) state_q <= ENT_DRAIN;
      if (clr_i) pend_q[clr_word_i] <= 1'b0;
      if (release_i) state_q <= ENT_FREE;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_i || merge_i) rds_q[word_i] <= rd_i;
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_rd_out
    assign rds_o[w*RD_W +: RD_W] = rds_q[w];
  end

  assign state_o = state_q;
  assign sent_o  = sent_q;
  assign line_o  = line_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/mshr_scoreboard.sv
module mshr_scoreboard #(
  parameter int NUM_REGS = 32,
  localparam int RD_W = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_empty_i,
  input  logic [RD_W-1:0]     empty_rd_i,
  input  logic                set_full_i,
  input  logic [RD_W-1:0]     full_rd_i,
  output logic [NUM_REGS-1:0] full_o
);
  logic [NUM_REGS-1:0] full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= '1;
    end else begin
      if (set_full_i) full_q[full_rd_i] <= 1'b1;
      if (set_empty_i) full_q[empty_rd_i] <= 1'b0;
    end
  end

  assign full_o = full_q;
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int WORDS       = 4,
  parameter int LINE_W      = 28,
  parameter int DATA_W      = 32,
  parameter int NUM_REGS    = 32,
  localparam int EI_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int WI_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int RD_W = $clog2(NUM_REGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    miss_valid,
  output logic                    miss_ready,
  input  logic [LINE_W-1:0]       miss_line,
  input  logic [WI_W-1:0]         miss_word,
  input  logic [RD_W-1:0]         miss_rd,
  output logic                    mreq_valid,
  input  logic                    mreq_ready,
  output logic [LINE_W-1:0]       mreq_line,
  output logic [EI_W-1:0]         mreq_idx,
  input  logic                    fill_valid,
  output logic                    fill_ready,
  input  logic [EI_W-1:0]         fill_idx,
  input  logic [WORDS*DATA_W-1:0] fill_data,
  output logic                    wb_valid,
  output logic [RD_W-1:0]         wb_rd,
  output logic [DATA_W-1:0]       wb_data,
  input  logic [RD_W-1:0]         dec_rs,
  output logic                    dec_hold
);
  ent_state_t                 state_w [NUM_ENTRIES];
  logic                       sent_w  [NUM_ENTRIES];
  logic [LINE_W-1:0]          line_w  [NUM_ENTRIES];
  logic [WORDS-1:0]           pend_w  [NUM_ENTRIES];
  logic [WORDS*RD_W-1:0]      rds_w   [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] hit_vec, free_vec, unsent_vec;
  logic [EI_W-1:0]        hit_idx, free_idx, arb_idx;
  logic                   any_hit, any_free, any_unsent;
  logic                   miss_acc, fill_acc, mreq_acc;
  logic                   hit_draining, slot_busy, all_busy;
  logic [NUM_REGS-1:0]    reg_full;

  logic                   drain_busy;
  logic [EI_W-1:0]        drain_idx;
  logic [WORDS*DATA_W-1:0] line_buf;
  logic [WI_W-1:0]        wb_word;
  logic                   wb_any;
  logic                   drain_done;

  logic                   lock_q;
  logic [EI_W-1:0]        lock_idx_q;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    logic alloc_e, merge_e, sent_e, drain_e, clr_e, rel_e;
    assign alloc_e = miss_acc && !any_hit && (free_idx == EI_W'(e));
    assign merge_e = miss_acc && any_hit && (hit_idx == EI_W'(e));
    assign sent_e  = mreq_acc && (mreq_idx == EI_W'(e));
    assign drain_e = fill_acc && (fill_idx == EI_W'(e));
    assign clr_e   = wb_valid && (drain_idx == EI_W'(e));
    assign rel_e   = drain_done && (drain_idx == EI_W'(e));

    mshr_entry #(.LINE_W(LINE_W), .WORDS(WORDS), .RD_W(RD_W)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_i   (alloc_e),
      .merge_i   (merge_e),
      .word_i    (miss_word),
      .rd_i      (miss_rd),
      .line_i    (miss_line),
      .sent_i    (sent_e),
      .drain_i   (drain_e),
      .clr_i     (clr_e),
      .clr_word_i(wb_word),
      .release_i (rel_e),
      .state_o   (state_w[e]),
      .sent_o    (sent_w[e]),
      .line_o    (line_w[e]),
      .pend_o    (pend_w[e]),
      .rds_o     (rds_w[e])
    );

    assign free_vec[e]   = (state_w[e] == ENT_FREE);
    assign hit_vec[e]    = !free_vec[e] && (line_w[e] == miss_line);
    assign unsent_vec[e] = !free_vec[e] && !sent_w[e];
  end

  mshr_lowest #(.N(NUM_ENTRIES)) u_hit_enc  (.req(hit_vec),    .idx(hit_idx),  .any(any_hit));
  mshr_lowest #(.N(NUM_ENTRIES)) u_free_enc (.req(free_vec),   .idx(free_idx), .any(any_free));
  mshr_lowest #(.N(NUM_ENTRIES)) u_req_enc  (.req(unsent_vec), .idx(arb_idx),  .any(any_unsent));

  // Miss acceptance
  assign all_busy     = !any_free;
  assign hit_draining = any_hit && (state_w[hit_idx] == ENT_DRAIN);
  assign slot_busy    = any_hit && pend_w[hit_idx][miss_word];
  assign miss_ready   = reg_full[miss_rd] &&
                        (any_hit ? (!hit_draining && !slot_busy) : any_free);
  assign miss_acc     = miss_valid && miss_ready;

  // Memory request arbitration with hold
  assign mreq_valid = lock_q || any_unsent;
  assign mreq_idx   = lock_q ? lock_idx_q : arb_idx;
  assign mreq_line  = line_w[mreq_idx];
  assign mreq_acc   = mreq_valid && mreq_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_q     <= mreq_valid && !mreq_ready;
      lock_idx_q <= mreq_idx;
    end
  end

  // Fill drain engine
  assign fill_ready = !drain_busy;
  assign fill_acc   = fill_valid && fill_ready;

  mshr_lowest #(.N(WORDS)) u_word_enc (.req(pend_w[drain_idx]), .idx(wb_word), .any(wb_any));

  assign wb_valid   = drain_busy && wb_any;
  assign drain_done = drain_busy && !wb_any;
  assign wb_rd      = rds_w[drain_idx][wb_word*RD_W +: RD_W];
  assign wb_data    = line_buf[wb_word*DATA_W +: DATA_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drain_busy <= 1'b0;
      drain_idx  <= '0;
      line_buf   <= '0;
    end else if (fill_acc) begin
      drain_busy <= 1'b1;
      drain_idx  <= fill_idx;
      line_buf   <= fill_data;
    end else if (drain_done) begin
      drain_busy <= 1'b0;
    end
  end

  mshr_scoreboard #(.NUM_REGS(NUM_REGS)) u_sb (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_empty_i(miss_acc),
    .empty_rd_i (miss_rd),
    .set_full_i (wb_valid),
    .full_rd_i  (wb_rd),
    .full_o     (reg_full)
  );

  assign dec_hold = !reg_full[dec_rs];
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int NUM_REGS = 32,
  parameter int EI_W     = 2,
  localparam int RD_W    = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                miss_valid,
  input logic                miss_ready,
  input logic [RD_W-1:0]     miss_rd,
  input logic                mreq_valid,
  input logic                mreq_ready,
  input logic [EI_W-1:0]     mreq_idx,
  input logic                fill_ready,
  input logic                wb_valid,
  input logic [RD_W-1:0]     wb_rd,
  input logic [NUM_REGS-1:0] reg_full,
  input logic                drain_busy,
  input logic                all_busy,
  input logic                any_hit,
  input logic                slot_busy
);
  p_held_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready |=> mreq_valid && (mreq_idx == $past(mreq_idx)));

  p_accept_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && miss_ready |=> !reg_full[$past(miss_rd)]);

  p_no_new_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    all_busy && !any_hit |-> !miss_ready);

  p_slot_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_busy |-> !miss_ready);

  p_empty_dest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_full[miss_rd] |-> !miss_ready);

  p_wb_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> reg_full[$past(wb_rd)]);

  p_fill_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drain_busy |-> !fill_ready);
endmodule

bind mshr_file mshr_file_chk #(.NUM_REGS(NUM_REGS), .EI_W(EI_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .miss_valid (miss_valid),
  .miss_ready (miss_ready),
  .miss_rd    (miss_rd),
  .mreq_valid (mreq_valid),
  .mreq_ready (mreq_ready),
  .mreq_idx   (mreq_idx),
  .fill_ready (fill_ready),
  .wb_valid   (wb_valid),
  .wb_rd      (wb_rd),
  .reg_full   (reg_full),
  .drain_busy (drain_busy),
  .all_busy   (all_busy),
  .any_hit    (any_hit),
  .slot_busy  (slot_busy)
);

// File: tb/tb_mshr_file.sv
module tb_mshr_file;
  localparam int NE = 4, NW = 4, LW = 28, DW = 32, NR = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic miss_valid = 1'b0, mreq_ready = 1'b0, fill_valid = 1'b0;
  logic [LW-1:0] miss_line = '0;
  logic [1:0] miss_word = '0, fill_idx = '0;
  logic [4:0] miss_rd = '0, dec_rs = '0;
  logic [NW*DW-1:0] fill_data = '0;
  logic miss_ready, mreq_valid, fill_ready, wb_valid, dec_hold;
  logic [LW-1:0] mreq_line;
  logic [1:0] mreq_idx;
  logic [4:0] wb_rd;
  logic [DW-1:0] wb_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mshr_file dut (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_line(miss_line),
    .miss_word(miss_word), .miss_rd(miss_rd),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_line(mreq_line),
    .mreq_idx(mreq_idx),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_idx(fill_idx),
    .fill_data(fill_data),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data),
    .dec_rs(dec_rs), .dec_hold(dec_hold)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_miss(input logic [LW-1:0] line, input int word, input int rd,
                         input bit exp_rdy, input string req);
    @(negedge clk);
    miss_line = line; miss_word = 2'(word); miss_rd = 5'(rd); miss_valid = 1'b1;
    #1;
    chk(miss_ready === exp_rdy, req, 64'(miss_ready), 64'(exp_rdy));
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic take_mreq(input int idx, input logic [LW-1:0] line, input string req);
    @(negedge clk);
    chk(mreq_valid === 1'b1, req, 64'(mreq_valid), 64'd1);
    chk(mreq_idx === 2'(idx), req, 64'(mreq_idx), 64'(idx));
    chk(mreq_line === line, req, 64'(mreq_line), 64'(line));
    mreq_ready = 1'b1;
    @(negedge clk);
    mreq_ready = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(mreq_valid === 1'b0, "R1 mreq", 64'(mreq_valid), 64'd0);
    chk(wb_valid === 1'b0, "R1 wb", 64'(wb_valid), 64'd0);
    chk(fill_ready === 1'b1, "R1 fill_ready", 64'(fill_ready), 64'd1);
    for (int r = 0; r < NR; r += 7) begin
      dec_rs = 5'(r); #1;
      chk(dec_hold === 1'b0, "R1 reg full", 64'(dec_hold), 64'd0);
    end
  endtask

  task automatic t_alloc_merge;
    do_miss(28'h100, 2, 5, 1'b1, "R2 alloc");
    dec_rs = 5'd5; #1;
    chk(dec_hold === 1'b1, "R4 hold", 64'(dec_hold), 64'd1);
    chk(mreq_valid === 1'b1 && mreq_idx === 2'd0, "R2 request", 64'(mreq_idx), 64'd0);
    @(negedge clk);
    chk(mreq_valid === 1'b1 && mreq_line === 28'h100, "R2 held", 64'(mreq_line), 64'h100);
    do_miss(28'h100, 0, 6, 1'b1, "R3 merge");
    do_miss(28'h100, 2, 7, 1'b0, "R6 slot taken");
    do_miss(28'h200, 1, 5, 1'b0, "R7 empty dest");
    take_mreq(0, 28'h100, "R2 take");
    #1;
    chk(mreq_valid === 1'b0, "R3 no second request", 64'(mreq_valid), 64'd0);
  endtask

  task automatic t_full;
    do_miss(28'h200, 1, 8, 1'b1, "R2 alloc B");
    do_miss(28'h300, 1, 9, 1'b1, "R2 alloc C");
    do_miss(28'h400, 1, 10, 1'b1, "R2 alloc D");
    take_mreq(1, 28'h200, "R10 lowest first");
    take_mreq(2, 28'h300, "R10 next");
    take_mreq(3, 28'h400, "R10 last");
    do_miss(28'h500, 0, 11, 1'b0, "R5 full stall");
    do_miss(28'h400, 3, 12, 1'b1, "R5 merge when full");
    #1;
    chk(mreq_valid === 1'b0, "R3 merge no request", 64'(mreq_valid), 64'd0);
  endtask

  task automatic t_fill;
    logic [NW*DW-1:0] d;
    for (int w = 0; w < NW; w++) d[w*DW +: DW] = 32'hA000_0000 + 32'(w);
    @(negedge clk);
    fill_idx = 2'd0; fill_data = d; fill_valid = 1'b1;
    #1;
    chk(fill_ready === 1'b1, "R8 fill ready", 64'(fill_ready), 64'd1);
    @(negedge clk);
    fill_valid = 1'b0;
    chk(wb_valid === 1'b1 && wb_rd === 5'd6, "R8 first word rd", 64'(wb_rd), 64'd6);
    chk(wb_data === 32'hA000_0000, "R8 first word data", 64'(wb_data), 64'hA0000000);
    chk(fill_ready === 1'b0, "R9 busy", 64'(fill_ready), 64'd0);
    @(negedge clk);
    chk(wb_valid === 1'b1 && wb_rd === 5'd5, "R8 second word rd", 64'(wb_rd), 64'd5);
    chk(wb_data === 32'hA000_0002, "R8 second word data", 64'(wb_data), 64'hA0000002);
    @(negedge clk);
    chk(wb_valid === 1'b0, "R8 writes done", 64'(wb_valid), 64'd0);
    chk(fill_ready === 1'b0, "R9 release cycle", 64'(fill_ready), 64'd0);
    miss_line = 28'h100; miss_word = 2'd1; miss_rd = 5'd13; #1;
    chk(miss_ready === 1'b0, "R9 draining line", 64'(miss_ready), 64'd0);
    dec_rs = 5'd5; #1;
    chk(dec_hold === 1'b0, "R8 rd5 full", 64'(dec_hold), 64'd0);
    dec_rs = 5'd6; #1;
    chk(dec_hold === 1'b0, "R8 rd6 full", 64'(dec_hold), 64'd0);
    @(negedge clk);
    chk(fill_ready === 1'b1, "R9 released", 64'(fill_ready), 64'd1);
    do_miss(28'h500, 0, 11, 1'b1, "R9 reuse entry");
    take_mreq(0, 28'h500, "R2 reuse lowest");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_alloc_merge();
    t_full();
    t_fill();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule